// File: doc/BRIEF.md
# Staged Load/Store Execution Pipeline

This block carries memory instructions from the scheduler through a fixed row of stages. Loads and stores use different stage timing. Each accepted instruction takes one slot that moves forward one stage per unstalled cycle. The slot holds a tag, an address, an access size in bytes, the write data, a store/load kind and a four-bit flag vector. Depending on the stage and the kind, the slot drives a strobe on one of these ports: address translation, data-cache read, store-queue update, ordering-violation query, or one of two writeback ports. The translation lookaside buffer (TLB), the cache, the store queue and the violation checker are all outside the block. Each of them sees only a one-cycle valid strobe with its payload.

Stage 0 only asks for translation. In stage 1 a load sends its cache read and a store sends its store-queue update, and both kinds send a violation query. A load takes the cache response while it sits in stage 2 and writes back in stage 3. A store writes back in stage 4. A cache-miss sideband names a tag. If that tag belongs to a load in flight, the block marks the load and pulses a load-cancel to the issue logic. Atomic operations are handed straight to a separate execute interface. A flush marks every entry squashed, and a stall freezes all stages.

Top module: `ldst_stage_pipe`

## Requirements
- R1: After reset, every valid strobe is low: tlbReqValid, dcReqValid, violQryValid, sqUpdValid, ldWbValid, stWbValid, loadCancel and amoValid.
- R2: An instruction is accepted when issValid is high, issIsAtomic is low and stall is low. With no stall, it raises tlbReqValid with its tag and address in the next cycle. No cache, store-queue or writeback strobe comes from stage 0.
- R3: With no stall, a load raises dcReqValid and violQryValid (violQryIsStore=0) two cycles after issue. It takes dcRespData in the cycle it sits in stage 2, when dcRespValid is high. Four cycles after issue it raises ldWbValid, carrying that response data.
- R4: With no stall, a store raises sqUpdValid and violQryValid (violQryIsStore=1) two cycles after issue. This strobe carries its address, its size and the issData captured at issue. The store raises stWbValid five cycles after issue.
- R5: The flag vector uses bit 0 for valid, bit 1 for replayed (taken from issReplayed), bit 2 for cache-miss and bit 3 for squashed. A writeback shows the entry's flags on ldWbFlags or stWbFlags.
- R6: When missValid names the tag of a valid load in flight, loadCancel is high in that same cycle. That load later writes back with flag bit 2 set.
- R7: When missValid names a store's tag, loadCancel stays low and the store writes back with flag bit 2 clear.
- R8: An atomic issue (issIsAtomic=1) raises amoValid with amoTag in the same cycle and never takes a pipeline slot, so it produces no translation, cache, query or writeback strobe.
- R9: A store raises sqUpdMisalign and stWbMisalign when it is not a vector access, its size is greater than 1 and its address is not a multiple of its size. Sizes are powers of two.
- R10: A flush sets the squashed flag on every valid entry, and on an instruction accepted in the same cycle. From the next cycle on, a squashed entry keeps moving but drives none of the translation, cache, query, store-queue or writeback strobes.
- R11: While stall is high, no entry moves, no non-atomic issue is accepted and no pipeline strobe is raised. Each stage strobe fires once per entry.
- R12: At most one instruction enters per cycle. On every port, entries appear in the order they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all stages and blocks issue |
| flush | input | 1 | Squashes all in-flight entries |
| issValid | input | 1 | Issue request from scheduler |
| issTag | input | TAG_W | Instruction tag |
| issAddr | input | ADDR_W | Effective address |
| issSize | input | SIZE_W | Access size in bytes (power of two) |
| issData | input | DATA_W | Store write data |
| issIsStore | input | 1 | 1 = store, 0 = load |
| issIsAtomic | input | 1 | Atomic operation, diverted to amo port |
| issIsVector | input | 1 | Vector access (exempt from misalign check) |
| issReplayed | input | 1 | Sets the replayed flag |
| amoValid | output | 1 | Atomic handed to separate execute path |
| amoTag | output | TAG_W | Tag of that atomic |
| tlbReqValid | output | 1 | Translation request (stage 0) |
| tlbReqTag | output | TAG_W | Translation request tag |
| tlbReqAddr | output | ADDR_W | Address to translate |
| dcReqValid | output | 1 | Load cache read (stage 1) |
| dcReqTag | output | TAG_W | Cache read tag |
| dcReqAddr | output | ADDR_W | Cache read address |
| dcRespValid | input | 1 | Cache response for the load in stage 2 |
| dcRespData | input | DATA_W | Cache response data |
| violQryValid | output | 1 | Ordering-violation query (stage 1) |
| violQryTag | output | TAG_W | Query tag |
| violQryAddr | output | ADDR_W | Query address |
| violQryIsStore | output | 1 | Query comes from a store |
| sqUpdValid | output | 1 | Store-queue update (stage 1) |
| sqUpdTag | output | TAG_W | Update tag |
| sqUpdAddr | output | ADDR_W | Update address |
| sqUpdSize | output | SIZE_W | Update size |
| sqUpdData | output | DATA_W | Captured store data |
| sqUpdMisalign | output | 1 | Store-address-misaligned exception |
| missValid | input | 1 | Cache-miss sideband |
| missTag | input | TAG_W | Tag the miss refers to |
| loadCancel | output | 1 | Cancel wakeups of the missing load |
| ldWbValid | output | 1 | Load writeback (stage 3) |
| ldWbTag | output | TAG_W | Load writeback tag |
| ldWbData | output | DATA_W | Load result |
| ldWbFlags | output | 4 | Load flag vector |
| stWbValid | output | 1 | Store writeback (stage 4) |
| stWbTag | output | TAG_W | Store writeback tag |
| stWbMisalign | output | 1 | Store-address-misaligned exception |
| stWbFlags | output | 4 | Store flag vector |

## Verification
The assertions check these properties on every cycle:
- The cache read and the store-queue update never fire together.
- Each violation query travels with the matching request of the same tag.
- A stall or the cycle after a flush leaves every strobe quiet.
- Atomics never reach translation.
- A misalign flag appears only on wide stores.
- A cancel appears only with a miss.

Only the scoreboard scenarios can show the stage latencies, the data path from issue and from the cache response into writeback, the flag values an entry collects, and in-order delivery across stalls. They also cover the silent discard of squashed work.

// File: rtl/ldst_pipe_pkg.sv
package ldst_pipe_pkg;
  // flag vector bit positions
  localparam int FLAG_VALID  = 0;
  localparam int FLAG_REPLAY = 1;
  localparam int FLAG_MISS   = 2;
  localparam int FLAG_SQUASH = 3;
  localparam int NUM_FLAGS   = 4;

  // fixed stage roles
  localparam int MEM_STAGE  = 1;
  localparam int RESP_STAGE = 2;

  typedef logic [NUM_FLAGS-1:0] flagVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // load slot 0 from issue inputs
    logic advance;  // all slots shift one stage
    logic capResp;  // load in RESP_STAGE takes cache data
  } pipeStrobe_t;
endpackage

// File: rtl/ldst_pipe_ctrl.sv
module ldst_pipe_ctrl
  import ldst_pipe_pkg::*;
#(
  parameter int TAG_W       = 6,
  parameter int LD_WB_STAGE = 3,
  parameter int ST_WB_STAGE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stall,
  input  logic             flush,
  input  logic             issValid,
  input  logic [TAG_W-1:0] issTag,
  input  logic             issIsStore,
  input  logic             issIsAtomic,
  input  logic             issReplayed,
  input  logic             dcRespValid,
  input  logic             missValid,
  input  logic [TAG_W-1:0] missTag,
  output pipeStrobe_t      strobe,
  output logic             tlbReqValid,
  output logic [TAG_W-1:0] tlbReqTag,
  output logic             dcReqValid,
  output logic [TAG_W-1:0] dcReqTag,
  output logic             violQryValid,
  output logic [TAG_W-1:0] violQryTag,
  output logic             violQryIsStore,
  output logic             sqUpdValid,
  output logic [TAG_W-1:0] sqUpdTag,
  output logic             loadCancel,
  output logic             ldWbValid,
  output logic [TAG_W-1:0] ldWbTag,
  output flagVec_t         ldWbFlags,
  output logic             stWbValid,
  output logic [TAG_W-1:0] stWbTag,
  output flagVec_t         stWbFlags
);
  localparam int DEPTH = ST_WB_STAGE + 1;

  flagVec_t         slotFlags [DEPTH];
  flagVec_t         updFlags  [DEPTH];
  logic [TAG_W-1:0] slotTag   [DEPTH];
  logic             slotStore [DEPTH];
  logic [DEPTH-1:0] missHitVec;
  flagVec_t         headFlags;
  logic             advance;
  logic             accept;

  assign advance = ~stall;
  assign accept  = issValid & ~issIsAtomic & ~stall;

  always_comb begin
    headFlags              = '0;
    headFlags[FLAG_VALID]  = 1'b1;
    headFlags[FLAG_REPLAY] = issReplayed;
    headFlags[FLAG_SQUASH] = flush;
  end

  // in-place flag updates: flush squash and load miss marking
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      updFlags[k]   = slotFlags[k];
      missHitVec[k] = slotFlags[k][FLAG_VALID] & ~slotStore[k] &
                      missValid & (slotTag[k] == missTag);
      if (slotFlags[k][FLAG_VALID] && flush) updFlags[k][FLAG_SQUASH] = 1'b1;
      if (missHitVec[k]) updFlags[k][FLAG_MISS] = 1'b1;
    end
  end

  assign loadCancel = |missHitVec;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotFlags[0] <= '0;
          slotTag[0]   <= '0;
          slotStore[0] <= 1'b0;
        end else if (advance) begin
          slotFlags[0] <= accept ? headFlags : '0;
          if (accept) begin
            slotTag[0]   <= issTag;
            slotStore[0] <= issIsStore;
          end
        end else begin
          slotFlags[0] <= updFlags[0];
        end
      end
    end else begin : g_body
      // a load leaving slot k-1 continues only below its writeback stage
      localparam bit LOAD_PASS = (k - 1) < LD_WB_STAGE;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotFlags[k] <= '0;
          slotTag[k]   <= '0;
          slotStore[k] <= 1'b0;
        end else if (advance) begin
          slotFlags[k] <= (updFlags[k-1][FLAG_VALID] && (slotStore[k-1] || LOAD_PASS))
                          ? updFlags[k-1] : '0;
          slotTag[k]   <= slotTag[k-1];
          slotStore[k] <= slotStore[k-1];
        end else begin
          slotFlags[k] <= updFlags[k];
        end
      end
    end
  end

  function automatic logic live(input flagVec_t f);
    return f[FLAG_VALID] & ~f[FLAG_SQUASH];
  endfunction

  always_comb begin
    strobe.accept  = accept;
    strobe.advance = advance;
    strobe.capResp = slotFlags[RESP_STAGE][FLAG_VALID] & ~slotStore[RESP_STAGE] & dcRespValid;

    tlbReqValid    = advance & live(slotFlags[0]);
    tlbReqTag      = slotTag[0];

    dcReqValid     = advance & live(slotFlags[MEM_STAGE]) & ~slotStore[MEM_STAGE];
    dcReqTag       = slotTag[MEM_STAGE];
    sqUpdValid     = advance & live(slotFlags[MEM_STAGE]) & slotStore[MEM_STAGE];
    sqUpdTag       = slotTag[MEM_STAGE];
    violQryValid   = advance & live(slotFlags[MEM_STAGE]);
    violQryTag     = slotTag[MEM_STAGE];
    violQryIsStore = slotStore[MEM_STAGE];

    ldWbValid      = advance & live(slotFlags[LD_WB_STAGE]) & ~slotStore[LD_WB_STAGE];
    ldWbTag        = slotTag[LD_WB_STAGE];
    ldWbFlags      = slotFlags[LD_WB_STAGE];
    stWbValid      = advance & live(slotFlags[ST_WB_STAGE]) & slotStore[ST_WB_STAGE];
    stWbTag        = slotTag[ST_WB_STAGE];
    stWbFlags      = slotFlags[ST_WB_STAGE];
  end
endmodule

// File: rtl/ldst_pipe_data.sv
module ldst_pipe_data
  import ldst_pipe_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int SIZE_W      = 4,
  parameter int LD_WB_STAGE = 3,
  parameter int ST_WB_STAGE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeStrobe_t       strobe,
  input  logic [ADDR_W-1:0] issAddr,
  input  logic [SIZE_W-1:0] issSize,
  input  logic [DATA_W-1:0] issData,
  input  logic              issIsStore,
  input  logic              issIsVector,
  input  logic [DATA_W-1:0] dcRespData,
  output logic [ADDR_W-1:0] tlbReqAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SIZE_W-1:0] sqUpdSize,
  output logic [DATA_W-1:0] sqUpdData,
  output logic              sqUpdMisalign,
  output logic [DATA_W-1:0] ldWbData,
  output logic              stWbMisalign
);
  localparam int DEPTH = ST_WB_STAGE + 1;

  logic [ADDR_W-1:0] slotAddr [DEPTH];
  logic [SIZE_W-1:0] slotSize [DEPTH];
  logic [DATA_W-1:0] slotData [DEPTH];
  logic              slotMis  [DEPTH];
  logic              issMis;
  logic [SIZE_W-1:0] sizeMask;

  // power-of-two size: misaligned when any address bit under the size is set
  assign sizeMask = issSize - SIZE_W'(1);
  assign issMis   = issIsStore & ~issIsVector & (issSize > SIZE_W'(1)) &
                    (|(issAddr[SIZE_W-1:0] & sizeMask));

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotAddr[0] <= '0;
          slotSize[0] <= '0;
          slotData[0] <= '0;
          slotMis[0]  <= 1'b0;
        end else if (strobe.accept) begin
          slotAddr[0] <= issAddr;
          slotSize[0] <= issSize;
          slotData[0] <= issIsStore ? issData : '0;
          slotMis[0]  <= issMis;
        end
      end
    end else begin : g_body
      localparam bit TAKE_RESP_IN  = (k - 1) == RESP_STAGE;
      localparam bit TAKE_RESP_NOW = k == RESP_STAGE;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slotAddr[k] <= '0;
          slotSize[k] <= '0;
          slotData[k] <= '0;
          slotMis[k]  <= 1'b0;
        end else if (strobe.advance) begin
          slotAddr[k] <= slotAddr[k-1];
          slotSize[k] <= slotSize[k-1];
          slotData[k] <= (TAKE_RESP_IN && strobe.capResp) ? dcRespData : slotData[k-1];
          slotMis[k]  <= slotMis[k-1];
        end else if (TAKE_RESP_NOW && strobe.capResp) begin
          slotData[k] <= dcRespData;
        end
      end
    end
  end

  assign tlbReqAddr    = slotAddr[0];
  assign memAddr       = slotAddr[MEM_STAGE];
  assign sqUpdSize     = slotSize[MEM_STAGE];
  assign sqUpdData     = slotData[MEM_STAGE];
  assign sqUpdMisalign = slotMis[MEM_STAGE];
  assign ldWbData      = slotData[LD_WB_STAGE];
  assign stWbMisalign  = slotMis[ST_WB_STAGE];
endmodule

// File: rtl/ldst_stage_pipe.sv
module ldst_stage_pipe
  import ldst_pipe_pkg::*;
#(
  parameter int TAG_W       = 6,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int SIZE_W      = 4,
  parameter int LD_WB_STAGE = 3,
  parameter int ST_WB_STAGE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              flush,
  input  logic              issValid,
  input  logic [TAG_W-1:0]  issTag,
  input  logic [ADDR_W-1:0] issAddr,
  input  logic [SIZE_W-1:0] issSize,
  input  logic [DATA_W-1:0] issData,
  input  logic              issIsStore,
  input  logic              issIsAtomic,
  input  logic              issIsVector,
  input  logic              issReplayed,
  output logic              amoValid,
  output logic [TAG_W-1:0]  amoTag,
  output logic              tlbReqValid,
  output logic [TAG_W-1:0]  tlbReqTag,
  output logic [ADDR_W-1:0] tlbReqAddr,
  output logic              dcReqValid,
  output logic [TAG_W-1:0]  dcReqTag,
  output logic [ADDR_W-1:0] dcReqAddr,
  input  logic              dcRespValid,
  input  logic [DATA_W-1:0] dcRespData,
  output logic              violQryValid,
  output logic [TAG_W-1:0]  violQryTag,
  output logic [ADDR_W-1:0] violQryAddr,
  output logic              violQryIsStore,
  output logic              sqUpdValid,
  output logic [TAG_W-1:0]  sqUpdTag,
  output logic [ADDR_W-1:0] sqUpdAddr,
  output logic [SIZE_W-1:0] sqUpdSize,
  output logic [DATA_W-1:0] sqUpdData,
  output logic              sqUpdMisalign,
  input  logic              missValid,
  input  logic [TAG_W-1:0]  missTag,
  output logic              loadCancel,
  output logic              ldWbValid,
  output logic [TAG_W-1:0]  ldWbTag,
  output logic [DATA_W-1:0] ldWbData,
  output logic [3:0]        ldWbFlags,
  output logic              stWbValid,
  output logic [TAG_W-1:0]  stWbTag,
  output logic              stWbMisalign,
  output logic [3:0]        stWbFlags
);
  pipeStrobe_t       strobe;
  logic [ADDR_W-1:0] memAddr;

  // atomics bypass the pipeline entirely
  assign amoValid = issValid & issIsAtomic;
  assign amoTag   = issTag;

  ldst_pipe_ctrl #(
    .TAG_W(TAG_W), .LD_WB_STAGE(LD_WB_STAGE), .ST_WB_STAGE(ST_WB_STAGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .flush(flush),
    .issValid(issValid), .issTag(issTag), .issIsStore(issIsStore),
    .issIsAtomic(issIsAtomic), .issReplayed(issReplayed),
    .dcRespValid(dcRespValid), .missValid(missValid), .missTag(missTag),
    .strobe(strobe),
    .tlbReqValid(tlbReqValid), .tlbReqTag(tlbReqTag),
    .dcReqValid(dcReqValid), .dcReqTag(dcReqTag),
    .violQryValid(violQryValid), .violQryTag(violQryTag), .violQryIsStore(violQryIsStore),
    .sqUpdValid(sqUpdValid), .sqUpdTag(sqUpdTag),
    .loadCancel(loadCancel),
    .ldWbValid(ldWbValid), .ldWbTag(ldWbTag), .ldWbFlags(ldWbFlags),
    .stWbValid(stWbValid), .stWbTag(stWbTag), .stWbFlags(stWbFlags)
  );

  ldst_pipe_data #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .LD_WB_STAGE(LD_WB_STAGE), .ST_WB_STAGE(ST_WB_STAGE)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issAddr(issAddr), .issSize(issSize), .issData(issData),
    .issIsStore(issIsStore), .issIsVector(issIsVector),
    .dcRespData(dcRespData),
    .tlbReqAddr(tlbReqAddr), .memAddr(memAddr),
    .sqUpdSize(sqUpdSize), .sqUpdData(sqUpdData), .sqUpdMisalign(sqUpdMisalign),
    .ldWbData(ldWbData), .stWbMisalign(stWbMisalign)
  );

  assign dcReqAddr   = memAddr;
  assign violQryAddr = memAddr;
  assign sqUpdAddr   = memAddr;
endmodule

// File: rtl/ldst_stage_pipe_chk.sv
module ldst_stage_pipe_chk #(
  parameter int TAG_W  = 6,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input logic              flush,
  input logic              issValid,
  input logic              issIsAtomic,
  input logic [TAG_W-1:0]  issTag,
  input logic              tlbReqValid,
  input logic [TAG_W-1:0]  tlbReqTag,
  input logic              dcReqValid,
  input logic [TAG_W-1:0]  dcReqTag,
  input logic              violQryValid,
  input logic [TAG_W-1:0]  violQryTag,
  input logic              violQryIsStore,
  input logic              sqUpdValid,
  input logic [TAG_W-1:0]  sqUpdTag,
  input logic [SIZE_W-1:0] sqUpdSize,
  input logic              sqUpdMisalign,
  input logic              missValid,
  input logic              loadCancel,
  input logic              ldWbValid,
  input logic [3:0]        ldWbFlags,
  input logic              stWbValid
);
  logic anyStrobe;
  assign anyStrobe = tlbReqValid | dcReqValid | violQryValid | sqUpdValid | ldWbValid | stWbValid;

  a_r2_tlb_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !issIsAtomic && !stall && !flush) |=>
      (stall || (tlbReqValid && tlbReqTag == $past(issTag))));

  a_r8_atomic_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && issIsAtomic && !stall) |=> !tlbReqValid);

  a_r3_mem_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dcReqValid && sqUpdValid));

  a_r4_query_pairs: assert property (@(posedge clk) disable iff (!rstN)
    violQryValid |-> (violQryIsStore ? (sqUpdValid && sqUpdTag == violQryTag)
                                     : (dcReqValid && dcReqTag == violQryTag)));

  a_r6_cancel_needs_miss: assert property (@(posedge clk) disable iff (!rstN)
    loadCancel |-> missValid);

  a_r9_misalign_wide_only: assert property (@(posedge clk) disable iff (!rstN)
    (sqUpdValid && sqUpdMisalign) |-> (sqUpdSize > SIZE_W'(1)));

  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !anyStrobe);

  a_r11_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !anyStrobe);

  a_r5_wb_flags_live: assert property (@(posedge clk) disable iff (!rstN)
    ldWbValid |-> (ldWbFlags[0] && !ldWbFlags[3]));
endmodule

bind ldst_stage_pipe ldst_stage_pipe_chk #(.TAG_W(TAG_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .flush(flush),
  .issValid(issValid), .issIsAtomic(issIsAtomic), .issTag(issTag),
  .tlbReqValid(tlbReqValid), .tlbReqTag(tlbReqTag),
  .dcReqValid(dcReqValid), .dcReqTag(dcReqTag),
  .violQryValid(violQryValid), .violQryTag(violQryTag), .violQryIsStore(violQryIsStore),
  .sqUpdValid(sqUpdValid), .sqUpdTag(sqUpdTag), .sqUpdSize(sqUpdSize),
  .sqUpdMisalign(sqUpdMisalign), .missValid(missValid), .loadCancel(loadCancel),
  .ldWbValid(ldWbValid), .ldWbFlags(ldWbFlags), .stWbValid(stWbValid)
);

// File: tb/ldst_stage_pipe_bench.sv
module ldst_stage_pipe_bench;
  localparam int TAG_W = 6, ADDR_W = 32, DATA_W = 64, SIZE_W = 4;

  logic clk = 1'b0, rstN = 1'b0, stall = 1'b0, flush = 1'b0;
  logic issValid = 1'b0, issIsStore = 1'b0, issIsAtomic = 1'b0, issIsVector = 1'b0, issReplayed = 1'b0;
  logic [TAG_W-1:0] issTag = '0, missTag = '0;
  logic [ADDR_W-1:0] issAddr = '0;
  logic [SIZE_W-1:0] issSize = '0;
  logic [DATA_W-1:0] issData = '0, dcRespData = '0;
  logic dcRespValid = 1'b0, missValid = 1'b0;

  logic amoValid, tlbReqValid, dcReqValid, violQryValid, violQryIsStore, sqUpdValid, sqUpdMisalign;
  logic loadCancel, ldWbValid, stWbValid, stWbMisalign;
  logic [TAG_W-1:0] amoTag, tlbReqTag, dcReqTag, violQryTag, sqUpdTag, ldWbTag, stWbTag;
  logic [ADDR_W-1:0] tlbReqAddr, dcReqAddr, violQryAddr, sqUpdAddr;
  logic [SIZE_W-1:0] sqUpdSize;
  logic [DATA_W-1:0] sqUpdData, ldWbData;
  logic [3:0] ldWbFlags, stWbFlags;

  ldst_stage_pipe u_ldst_stage_pipe (
    .clk(clk), .rstN(rstN), .stall(stall), .flush(flush),
    .issValid(issValid), .issTag(issTag), .issAddr(issAddr), .issSize(issSize),
    .issData(issData), .issIsStore(issIsStore), .issIsAtomic(issIsAtomic),
    .issIsVector(issIsVector), .issReplayed(issReplayed),
    .amoValid(amoValid), .amoTag(amoTag),
    .tlbReqValid(tlbReqValid), .tlbReqTag(tlbReqTag), .tlbReqAddr(tlbReqAddr),
    .dcReqValid(dcReqValid), .dcReqTag(dcReqTag), .dcReqAddr(dcReqAddr),
    .dcRespValid(dcRespValid), .dcRespData(dcRespData),
    .violQryValid(violQryValid), .violQryTag(violQryTag), .violQryAddr(violQryAddr),
    .violQryIsStore(violQryIsStore),
    .sqUpdValid(sqUpdValid), .sqUpdTag(sqUpdTag), .sqUpdAddr(sqUpdAddr),
    .sqUpdSize(sqUpdSize), .sqUpdData(sqUpdData), .sqUpdMisalign(sqUpdMisalign),
    .missValid(missValid), .missTag(missTag), .loadCancel(loadCancel),
    .ldWbValid(ldWbValid), .ldWbTag(ldWbTag), .ldWbData(ldWbData), .ldWbFlags(ldWbFlags),
    .stWbValid(stWbValid), .stWbTag(stWbTag), .stWbMisalign(stWbMisalign), .stWbFlags(stWbFlags)
  );

  always #5 clk = ~clk;

  typedef struct {
    int tag; logic [31:0] addr; logic [63:0] data; int sz; bit mis; bit st;
    logic [3:0] flags; int issCyc; int lat;
  } exp_t;

  exp_t tlbQ[$], dcQ[$], violQ[$], sqQ[$], ldQ[$], stQ[$];
  int nChecks = 0, nFails = 0, cycCnt = 0;
  bit done = 1'b0;

  function automatic logic [63:0] cacheData(input logic [31:0] a);
    return {a, a ^ 32'h5A5A_F00F};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycCnt <= cycCnt + 1;
    if (cycCnt > 20000 && !done) begin
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected below 20000", cycCnt);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // cache model: answers a read in the cycle the load sits in stage 2
  bit pendV = 1'b0;
  logic [31:0] pendA = '0;
  always @(negedge clk) begin
    #3;
    dcRespValid = pendV;
    dcRespData  = cacheData(pendA);
    pendV = dcReqValid;
    pendA = dcReqAddr;
  end

  task automatic popCheck(ref exp_t q[$], input string rq, input string port,
                          input int tag, output exp_t e, output bit got);
    got = 1'b0;
    if (q.size() == 0) begin
      check(1'b0, rq, {port, " unexpected strobe, tag"}, tag, -1);
      return;
    end
    e = q.pop_front();
    got = 1'b1;
    check(tag == e.tag, rq, {port, " tag (R12 order)"}, tag, e.tag);
    if (e.lat >= 0) check(cycCnt - e.issCyc == e.lat, rq, {port, " latency"}, cycCnt - e.issCyc, e.lat);
  endtask

  // monitor: compares each strobe against the scoreboard
  always @(negedge clk) begin
    exp_t e; bit got;
    #3;
    if (rstN && !done) begin
      if (stall && (tlbReqValid || dcReqValid || violQryValid || sqUpdValid || ldWbValid || stWbValid))
        check(1'b0, "R11", "strobe during stall", 1, 0);
      if (tlbReqValid) begin
        popCheck(tlbQ, "R2", "tlb", int'(tlbReqTag), e, got);
        if (got) check(tlbReqAddr == e.addr, "R2", "tlb addr", tlbReqAddr, e.addr);
      end
      if (dcReqValid) begin
        popCheck(dcQ, "R3", "dcache", int'(dcReqTag), e, got);
        if (got) check(dcReqAddr == e.addr, "R3", "dcache addr", dcReqAddr, e.addr);
      end
      if (violQryValid) begin
        popCheck(violQ, "R4", "query", int'(violQryTag), e, got);
        if (got) check(violQryIsStore == e.st && violQryAddr == e.addr, "R4", "query kind/addr",
                       {violQryIsStore, violQryAddr}, {e.st, e.addr});
      end
      if (sqUpdValid) begin
        popCheck(sqQ, "R4", "sq", int'(sqUpdTag), e, got);
        if (got) begin
          check(sqUpdData == e.data && sqUpdAddr == e.addr && int'(sqUpdSize) == e.sz,
                "R4", "sq data", sqUpdData, e.data);
          check(sqUpdMisalign == e.mis, "R9", "sq misalign", sqUpdMisalign, e.mis);
        end
      end
      if (ldWbValid) begin
        popCheck(ldQ, "R3", "ldwb", int'(ldWbTag), e, got);
        if (got) begin
          check(ldWbData == e.data, "R3", "ldwb data", ldWbData, e.data);
          check(ldWbFlags == e.flags, "R5", "ldwb flags", ldWbFlags, e.flags);
        end
      end
      if (stWbValid) begin
        popCheck(stQ, "R4", "stwb", int'(stWbTag), e, got);
        if (got) begin
          check(stWbMisalign == e.mis, "R9", "stwb misalign", stWbMisalign, e.mis);
          check(stWbFlags == e.flags, "R5", "stwb flags", stWbFlags, e.flags);
        end
      end
    end
  end

  // drop: 0 = full life, 1 = translation only, 2 = nothing
  task automatic issueOp(input int tg, input logic [31:0] ad, input int sz, input bit st,
                         input bit vec, input bit rep, input logic [63:0] dt,
                         input bit expMiss, input int drop, input bit fl, input bit timed);
    exp_t e;
    e.tag = tg; e.addr = ad; e.sz = sz; e.st = st; e.issCyc = cycCnt;
    e.mis = st && !vec && sz > 1 && (ad % sz) != 0;
    e.flags = {1'b0, expMiss, rep, 1'b1};
    issValid = 1'b1; issTag = TAG_W'(tg); issAddr = ad; issSize = SIZE_W'(sz);
    issIsStore = st; issIsVector = vec; issReplayed = rep; issData = dt; issIsAtomic = 1'b0;
    flush = fl;
    if (drop < 2) begin e.lat = timed ? 1 : -1; tlbQ.push_back(e); end
    if (drop == 0) begin
      e.lat = timed ? 2 : -1;
      violQ.push_back(e);
      if (st) begin
        e.data = dt; sqQ.push_back(e);
        e.lat = timed ? 5 : -1; stQ.push_back(e);
      end else begin
        dcQ.push_back(e);
        e.data = cacheData(ad); e.lat = timed ? 4 : -1; ldQ.push_back(e);
      end
    end
    @(negedge clk);
    issValid = 1'b0; flush = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #3;
    // R1 reset state
    check(!tlbReqValid && !dcReqValid && !violQryValid && !sqUpdValid, "R1", "req strobes after reset",
          {tlbReqValid, dcReqValid, violQryValid, sqUpdValid}, 0);
    check(!ldWbValid && !stWbValid && !loadCancel && !amoValid, "R1", "wb/cancel after reset",
          {ldWbValid, stWbValid, loadCancel, amoValid}, 0);
    @(negedge clk);

    // R2 R3 R4 R12: back-to-back mix, timed
    issueOp(1, 32'h0000_1000, 8, 0, 0, 0, 64'h0, 0, 0, 0, 1);
    issueOp(2, 32'h0000_2008, 8, 1, 0, 0, 64'hDEAD_BEEF_0123_4567, 0, 0, 0, 1);
    issueOp(3, 32'h0000_3004, 4, 0, 0, 1, 64'h0, 0, 0, 0, 1);
    issueOp(4, 32'h0000_4000, 2, 1, 0, 1, 64'h1111_2222_3333_4444, 0, 0, 0, 1);
    idle(8);

    // R9 misalign cases
    issueOp(5, 32'h0000_0102, 4, 1, 0, 0, 64'hA5, 0, 0, 0, 1);  // misaligned
    issueOp(6, 32'h0000_0103, 1, 1, 0, 0, 64'hB6, 0, 0, 0, 1);  // byte: never
    issueOp(7, 32'h0000_0106, 4, 1, 1, 0, 64'hC7, 0, 0, 0, 1);  // vector: exempt
    issueOp(8, 32'h0000_0108, 8, 1, 0, 0, 64'hD8, 0, 0, 0, 1);  // aligned
    idle(8);

    // R6: miss on a load
    issueOp(9, 32'h0000_5000, 8, 0, 0, 0, 64'h0, 1, 0, 0, 1);
    missValid = 1'b1; missTag = 9;
    #3 check(loadCancel == 1'b1, "R6", "cancel on load miss", loadCancel, 1);
    @(negedge clk); missValid = 1'b0;
    idle(6);

    // R7: miss on a store
    issueOp(10, 32'h0000_6000, 8, 1, 0, 0, 64'h77, 0, 0, 0, 1);
    missValid = 1'b1; missTag = 10;
    #3 check(loadCancel == 1'b0, "R7", "no cancel on store miss", loadCancel, 0);
    @(negedge clk); missValid = 1'b0;
    idle(7);

    // R8: atomic bypass
    issValid = 1'b1; issIsAtomic = 1'b1; issTag = 11; issIsStore = 1'b1;
    #3 check(amoValid && amoTag == 11, "R8", "amo handoff", {amoValid, amoTag}, {1'b1, 6'd11});
    @(negedge clk); issValid = 1'b0; issIsAtomic = 1'b0;
    idle(6);

    // R10: flush squashes an entry in flight and one entering
    issueOp(20, 32'h0000_7000, 8, 0, 0, 0, 64'h0, 0, 1, 0, 1);
    issueOp(21, 32'h0000_7008, 8, 1, 0, 0, 64'h99, 0, 2, 1, 1);
    idle(7);
    check(tlbQ.size() == 0 && ldQ.size() == 0 && stQ.size() == 0, "R10", "squashed work silent",
          tlbQ.size() + ldQ.size() + stQ.size(), 0);

    // R11: stall mid-flight, issue ignored during stall
    issueOp(30, 32'h0000_8000, 8, 0, 0, 0, 64'h0, 0, 0, 0, 0);
    issueOp(31, 32'h0000_8010, 8, 1, 0, 0, 64'h3131, 0, 0, 0, 0);
    issueOp(32, 32'h0000_8020, 4, 0, 0, 0, 64'h0, 0, 0, 0, 0);
    stall = 1'b1;
    issValid = 1'b1; issTag = 40; issAddr = 32'h9000; issIsStore = 1'b0;
    idle(3);
    issValid = 1'b0; stall = 1'b0;
    idle(2);
    stall = 1'b1; idle(2); stall = 1'b0;
    idle(10);

    // end: all expected items delivered
    check(tlbQ.size() == 0, "R2", "tlb queue drained", tlbQ.size(), 0);
    check(dcQ.size() == 0, "R3", "dcache queue drained", dcQ.size(), 0);
    check(violQ.size() == 0, "R4", "query queue drained", violQ.size(), 0);
    check(sqQ.size() == 0, "R4", "sq queue drained", sqQ.size(), 0);
    check(ldQ.size() == 0, "R3", "ldwb queue drained", ldQ.size(), 0);
    check(stQ.size() == 0, "R11", "stwb queue drained", stQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule